// File: doc/BRIEF.md
# E1 AIS Alarm Detector

This block watches a received E1 bit stream for an alarm indication signal. An upstream framer has already found the frame and multiframe boundaries. It supplies one strobe per bit, one strobe on the first bit of each 256-bit frame, and one strobe on the first bit of each 16-frame multiframe. A two-bit mode input selects the criterion. Mode 01 checks the whole frame for ones. Mode 11 checks for ones on every bit except timeslot 0. Mode 10 checks for ones in timeslot 16 only. Mode 00 turns detection off.

Each observation period is either a valid alarm period or a clean one. An up/down counter integrates these results. When the counter reaches its threshold, the alarm is declared. When the counter drains back to zero, the alarm is cleared. The block reports the alarm as a level and keeps a sticky change flag that a status read clears. It raises an interrupt only while both the source enable and the block enable are set.

Top module: `ais_detector_e1`

## Requirements
- R1: A synchronous active-high reset clears the integration counter, `ais_state`, `ais_chg` and `irq` to 0.
- R2: In mode 01, a period spans two frames (512 bits). It is a valid alarm period when it contains fewer than 3 zeros. Every bit of the frame counts, including timeslot 0.
- R3: In mode 11, the period is also two frames. The bits of timeslot 0 are ignored: these are frame bit positions 0 to 7, where position 0 is the bit that carries `frame_start`. The period is valid when the remaining bits hold fewer than 3 zeros.
- R4: In mode 10, a period runs from one `mf_start` to the next (16 frames). It is valid only if every bit of timeslot 16 (frame positions 128 to 135) is 1 throughout. Other timeslots have no effect.
- R5: In mode 00, nothing is detected. `ais_state` stays 0 and no change event occurs, whatever the line carries.
- R6: Each valid period increments the counter, which saturates at 4. The alarm (`ais_state` = 1) is declared when the counter reaches 4.
- R7: Each invalid period decrements a nonzero counter. A declared alarm is cleared when the counter reaches 0.
- R8: Changing `det_sel`, or holding it at 00, clears the counter and `ais_state` without setting `ais_chg`. The first period after a change restarts from a fresh boundary.
- R9: `ais_chg` is set one cycle after every declare or clear that the counter causes. It holds until a cycle with `stat_rd` = 1. A new event in that same cycle wins over the read.
- R10: `irq` is an active-high level that is 1 exactly when `ais_chg`, `chg_ie` and `blk_ie` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Received serial data bit |
| bit_en | input | 1 | Qualifies `rx_bit` and the strobes in this cycle |
| frame_start | input | 1 | Marks the first bit of a frame |
| mf_start | input | 1 | Marks the first bit of a multiframe (asserted together with `frame_start`) |
| det_sel | input | 2 | Detection mode: 00 off, 01 unframed, 10 timeslot 16, 11 framed |
| chg_ie | input | 1 | Interrupt enable for the alarm-change source |
| blk_ie | input | 1 | Block-level interrupt enable |
| stat_rd | input | 1 | Status read strobe; clears `ais_chg` |
| ais_state | output | 1 | Alarm declared |
| ais_chg | output | 1 | Sticky alarm state change flag |
| irq | output | 1 | Interrupt request level |

## Verification
The properties assume that `mf_start` only occurs together with `frame_start` and `bit_en`. They also assume that `det_sel` changes are plain level changes with no further protocol. The transitions they check therefore come only from period results or mode clears. The stimulus always sends whole 256-bit frames, with strobes on position 0 only. It changes the mode, and pulses `stat_rd`, only in idle cycles between frames. Multiframe starts fall on every sixteenth frame of each run.

// File: rtl/ais_pkg.sv
package ais_pkg;

    parameter int E1_FRAME_BITS = 256;
    parameter int E1_SLOT_BITS  = 8;
    parameter int E1_SIG_SLOT   = 16;
    parameter int WIN_FRAMES    = 2;
    parameter int ZERO_LIMIT    = 3;
    parameter int INTEG_THRESH  = 4;

    typedef enum logic [1:0] {
        DET_OFF  = 2'b00,
        DET_UNFR = 2'b01,
        DET_TS16 = 2'b10,
        DET_FRM  = 2'b11
    } det_mode_e;

    typedef struct packed {
        logic tick;
        logic ok;
    } period_t;

    function automatic logic bit_in_check(det_mode_e m, int unsigned slot);
        return (m == DET_UNFR) || ((m == DET_FRM) && (slot != 0));
    endfunction

endpackage

// File: rtl/ais_bitpos.sv
module ais_bitpos
    import ais_pkg::*;
#(
    parameter int FRAME_BITS = E1_FRAME_BITS,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             frame_start,
    output logic [POS_W-1:0] pos
);

    logic [POS_W-1:0] nxt_pos;

    assign pos = frame_start ? '0 : nxt_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_pos <= '0;
        end else if (bit_en) begin
            nxt_pos <= pos + POS_W'(1);
        end
    end

endmodule

// File: rtl/ais_window.sv
module ais_window
    import ais_pkg::*;
#(
    parameter int FRAME_BITS = E1_FRAME_BITS,
    parameter int SLOT_BITS  = E1_SLOT_BITS,
    parameter int SIG_SLOT   = E1_SIG_SLOT,
    parameter int FRAMES     = WIN_FRAMES,
    parameter int ZLIM       = ZERO_LIMIT,
    localparam int POS_W = $clog2(FRAME_BITS),
    localparam int SB_W  = $clog2(SLOT_BITS),
    localparam int IDX_W = POS_W - SB_W,
    localparam int ZC_W  = $clog2(ZLIM + 1),
    localparam int FC_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  det_mode_e        mode,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             frame_start,
    input  logic             mf_start,
    input  logic [POS_W-1:0] pos,
    output period_t          per
);

    logic [IDX_W-1:0] slot;
    logic             zero_hit;
    logic             sig_hit;
    logic [ZC_W-1:0]  zcnt, zacc, zfresh;
    logic [FC_W-1:0]  fcnt;
    logic             fr_sync, mf_sync, sig_bad;

    assign slot     = pos[POS_W-1:SB_W];
    assign zero_hit = !rx_bit && bit_in_check(mode, 32'(slot));
    assign sig_hit  = !rx_bit && (slot == IDX_W'(SIG_SLOT));
    assign zfresh   = ZC_W'(zero_hit);
    assign zacc     = (zcnt == ZC_W'(ZLIM)) ? zcnt : zcnt + ZC_W'(zero_hit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            per     <= '0;
            zcnt    <= '0;
            fcnt    <= '0;
            fr_sync <= 1'b0;
            mf_sync <= 1'b0;
            sig_bad <= 1'b0;
        end else begin
            per <= '0;
            if (bit_en) begin
                case (mode)
                    DET_UNFR, DET_FRM: begin
                        if (frame_start) begin
                            if (!fr_sync) begin
                                fr_sync <= 1'b1;
                                fcnt    <= '0;
                                zcnt    <= zfresh;
                            end else if (fcnt == FC_W'(FRAMES - 1)) begin
                                per.tick <= 1'b1;
                                per.ok   <= (zcnt < ZC_W'(ZLIM));
                                fcnt     <= '0;
                                zcnt     <= zfresh;
                            end else begin
                                fcnt <= fcnt + FC_W'(1);
                                zcnt <= zacc;
                            end
                        end else begin
                            zcnt <= zacc;
                        end
                    end
                    DET_TS16: begin
                        if (mf_start) begin
                            if (!mf_sync) begin
                                mf_sync <= 1'b1;
                            end else begin
                                per.tick <= 1'b1;
                                per.ok   <= !sig_bad;
                            end
                            sig_bad <= sig_hit;
                        end else if (sig_hit) begin
                            sig_bad <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ais_integrator.sv
module ais_integrator
    import ais_pkg::*;
#(
    parameter int THRESH = INTEG_THRESH,
    localparam int CNT_W = $clog2(THRESH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  period_t          per,
    output logic [CNT_W-1:0] cnt,
    output logic             state,
    output logic             evt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            state <= 1'b0;
            evt   <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (per.tick) begin
                if (per.ok) begin
                    if (cnt != CNT_W'(THRESH)) begin
                        cnt <= cnt + CNT_W'(1);
                        if ((cnt == CNT_W'(THRESH - 1)) && !state) begin
                            state <= 1'b1;
                            evt   <= 1'b1;
                        end
                    end
                end else if (cnt != '0) begin
                    cnt <= cnt - CNT_W'(1);
                    if ((cnt == CNT_W'(1)) && state) begin
                        state <= 1'b0;
                        evt   <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ais_status.sv
module ais_status (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic stat_rd,
    input  logic chg_ie,
    input  logic blk_ie,
    output logic chg,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chg <= 1'b0;
        end else if (evt) begin
            chg <= 1'b1;
        end else if (stat_rd) begin
            chg <= 1'b0;
        end
    end

    assign irq = chg & chg_ie & blk_ie;

endmodule

// File: rtl/ais_detector_e1.sv
module ais_detector_e1
    import ais_pkg::*;
#(
    parameter int FRAME_BITS = E1_FRAME_BITS,
    parameter int SLOT_BITS  = E1_SLOT_BITS,
    parameter int SIG_SLOT   = E1_SIG_SLOT,
    parameter int FRAMES     = WIN_FRAMES,
    parameter int ZLIM       = ZERO_LIMIT,
    parameter int THRESH     = INTEG_THRESH,
    localparam int POS_W = $clog2(FRAME_BITS),
    localparam int CNT_W = $clog2(THRESH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       bit_en,
    input  logic       frame_start,
    input  logic       mf_start,
    input  logic [1:0] det_sel,
    input  logic       chg_ie,
    input  logic       blk_ie,
    input  logic       stat_rd,
    output logic       ais_state,
    output logic       ais_chg,
    output logic       irq
);

    det_mode_e        mode;
    logic [1:0]       prev_sel;
    logic             mode_clr;
    logic [POS_W-1:0] pos;
    period_t          per;
    logic [CNT_W-1:0] intg_cnt;
    logic             intg_evt;

    assign mode     = det_mode_e'(det_sel);
    assign mode_clr = (det_sel != prev_sel) || (mode == DET_OFF);

    always_ff @(posedge clk) begin
        prev_sel <= det_sel;
    end

    ais_bitpos #(.FRAME_BITS(FRAME_BITS)) u_pos (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .frame_start(frame_start), .pos(pos)
    );

    ais_window #(
        .FRAME_BITS(FRAME_BITS), .SLOT_BITS(SLOT_BITS), .SIG_SLOT(SIG_SLOT),
        .FRAMES(FRAMES), .ZLIM(ZLIM)
    ) u_win (
        .clk(clk), .rst(rst), .clr(mode_clr), .mode(mode),
        .bit_en(bit_en), .rx_bit(rx_bit), .frame_start(frame_start),
        .mf_start(mf_start), .pos(pos), .per(per)
    );

    ais_integrator #(.THRESH(THRESH)) u_intg (
        .clk(clk), .rst(rst), .clr(mode_clr), .per(per),
        .cnt(intg_cnt), .state(ais_state), .evt(intg_evt)
    );

    ais_status u_stat (
        .clk(clk), .rst(rst), .evt(intg_evt), .stat_rd(stat_rd),
        .chg_ie(chg_ie), .blk_ie(blk_ie), .chg(ais_chg), .irq(irq)
    );

endmodule

// File: rtl/ais_det_chk.sv
module ais_det_chk #(
    parameter int THRESH = 4,
    localparam int CNT_W = $clog2(THRESH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       det_sel,
    input logic             stat_rd,
    input logic             chg_ie,
    input logic             blk_ie,
    input logic             ais_state,
    input logic             ais_chg,
    input logic             irq,
    input logic [CNT_W-1:0] cnt
);

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(THRESH));

    // R6
    declare_at_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ais_state) |-> (cnt == CNT_W'(THRESH)));

    // R7
    clear_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ais_state) |-> (cnt == '0));

    // R5
    off_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (det_sel == 2'b00) |=> (!ais_state && cnt == '0));

    // R8
    mode_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (det_sel != $past(det_sel)) |=> (!ais_state && cnt == '0));

    // R9
    chg_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ais_state) |=> ais_chg);

    // R9
    chg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ais_chg && !stat_rd) |=> ais_chg);

    // R10
    irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (chg_ie && blk_ie));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        (ais_chg && chg_ie && blk_ie) |-> irq);

endmodule

bind ais_detector_e1 ais_det_chk #(.THRESH(THRESH)) u_chk (
    .clk(clk), .rst(rst), .det_sel(det_sel), .stat_rd(stat_rd),
    .chg_ie(chg_ie), .blk_ie(blk_ie), .ais_state(ais_state),
    .ais_chg(ais_chg), .irq(irq), .cnt(intg_cnt)
);

// File: tb/tb_ais_detector_e1.sv
module tb_ais_detector_e1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b1, bit_en = 1'b0, frame_start = 1'b0, mf_start = 1'b0;
    logic [1:0] det_sel = 2'b00;
    logic       chg_ie = 1'b0, blk_ie = 1'b0, stat_rd = 1'b0;
    logic       ais_state, ais_chg, irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ais_detector_e1 dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_en(bit_en),
        .frame_start(frame_start), .mf_start(mf_start), .det_sel(det_sel),
        .chg_ie(chg_ie), .blk_ie(blk_ie), .stat_rd(stat_rd),
        .ais_state(ais_state), .ais_chg(ais_chg), .irq(irq)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] ts0;
        logic [4:0] zts;
        logic [3:0] nz;
        logic [3:0] reps;
        logic       exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'b01, 8'hFF, 5'd5,  4'd0, 4'd4, 1'b1},
        '{2'b01, 8'hFF, 5'd5,  4'd0, 4'd3, 1'b0},
        '{2'b01, 8'hFF, 5'd5,  4'd1, 4'd4, 1'b1},
        '{2'b01, 8'hFF, 5'd5,  4'd2, 4'd4, 1'b0},
        '{2'b01, 8'h9B, 5'd5,  4'd0, 4'd4, 1'b0},
        '{2'b11, 8'h9B, 5'd5,  4'd0, 4'd4, 1'b1},
        '{2'b11, 8'h9B, 5'd3,  4'd1, 4'd4, 1'b1},
        '{2'b11, 8'h9B, 5'd16, 4'd2, 4'd4, 1'b0},
        '{2'b00, 8'hFF, 5'd5,  4'd0, 4'd4, 1'b0},
        '{2'b10, 8'h9B, 5'd5,  4'd8, 4'd4, 1'b1},
        '{2'b10, 8'hFF, 5'd16, 4'd1, 4'd4, 1'b0}
    };

    function automatic string vec_req(int i);
        case (i)
            1:       return "R6";
            5, 6, 7: return "R3";
            8:       return "R5";
            9, 10:   return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic send_frame(input logic [7:0] ts0, input int zts, input int nz, input logic ms);
        for (int p = 0; p < 256; p++) begin
            logic b;
            b = 1'b1;
            if (p < 8) b = ts0[7 - p];
            if (nz > 0 && (p / 8) == zts && (p % 8) < nz) b = 1'b0;
            rx_bit      = b;
            bit_en      = 1'b1;
            frame_start = (p == 0);
            mf_start    = (p == 0) && ms;
            @(negedge clk);
        end
        bit_en      = 1'b0;
        frame_start = 1'b0;
        mf_start    = 1'b0;
        rx_bit      = 1'b1;
    endtask

    task automatic send_run(input logic [7:0] ts0, input int zts, input int nz, input int n);
        for (int f = 0; f < n; f++) send_frame(ts0, zts, nz, (f % 16) == 0);
        idle(4);
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        idle(1);
        stat_rd = 1'b0;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1", "state after reset", ais_state, 0);
        chk("R1", "chg after reset", ais_chg, 0);
        chk("R1", "irq after reset", irq, 0);

        // Vector table: modes R2 R3 R4 R5 and threshold R6
        for (int i = 0; i < NV; i++) begin
            int nfr;
            det_sel = VEC[i].mode;
            chg_ie  = 1'b1;
            blk_ie  = 1'b1;
            do_reset();
            nfr = (VEC[i].mode == 2'b10) ? int'(VEC[i].reps) * 16 + 1 : int'(VEC[i].reps) * 2 + 1;
            send_run(VEC[i].ts0, int'(VEC[i].zts), int'(VEC[i].nz), nfr);
            chk(vec_req(i), $sformatf("vec%0d state", i), ais_state, int'(VEC[i].exp));
            chk(vec_req(i), $sformatf("vec%0d chg", i), ais_chg, int'(VEC[i].exp));
            chk(vec_req(i), $sformatf("vec%0d irq", i), irq, int'(VEC[i].exp));
        end

        // R6 saturation and R7 clearing, R9 sticky flag
        det_sel = 2'b01;
        do_reset();
        send_run(8'hFF, 5, 0, 17);
        chk("R6", "declared after 8 good periods", ais_state, 1);
        read_status();
        chk("R9", "chg cleared by read", ais_chg, 0);
        chk("R10", "irq low after read", irq, 0);
        send_run(8'hFF, 5, 3, 6);
        chk("R6", "held after 3 bad periods (saturated at 4)", ais_state, 1);
        chk("R9", "chg stays clear without event", ais_chg, 0);
        send_run(8'hFF, 5, 3, 2);
        chk("R7", "cleared when counter reaches 0", ais_state, 0);
        chk("R9", "chg set on clear", ais_chg, 1);

        // R10 enable gating, R9 flag holds
        chg_ie = 1'b0; blk_ie = 1'b1; idle(1);
        chk("R10", "irq with source enable off", irq, 0);
        chg_ie = 1'b1; blk_ie = 1'b0; idle(1);
        chk("R10", "irq with block enable off", irq, 0);
        blk_ie = 1'b1; idle(1);
        chk("R10", "irq with both enables", irq, 1);
        chk("R9", "chg held while unread", ais_chg, 1);

        // R8 mode change clears counter and state
        det_sel = 2'b01;
        do_reset();
        send_run(8'hFF, 5, 0, 9);
        chk("R6", "declared before mode switch", ais_state, 1);
        read_status();
        det_sel = 2'b11;
        idle(2);
        chk("R8", "state cleared on mode switch", ais_state, 0);
        chk("R8", "no chg on mode switch", ais_chg, 0);
        send_run(8'hFF, 5, 0, 7);
        chk("R8", "counter restarted from zero", ais_state, 0);
        send_run(8'hFF, 5, 0, 2);
        chk("R8", "declares after 4 fresh periods", ais_state, 1);

        // R5 selecting off clears state
        read_status();
        det_sel = 2'b00;
        idle(2);
        chk("R5", "state cleared when off", ais_state, 0);
        chk("R5", "no chg when turned off", ais_chg, 0);
        send_run(8'hFF, 5, 0, 9);
        chk("R5", "no detection while off", ais_state, 0);

        // R1 reset while declared
        det_sel = 2'b01;
        idle(2);
        send_run(8'hFF, 5, 0, 9);
        do_reset();
        chk("R1", "state cleared by reset", ais_state, 0);
        chk("R1", "chg cleared by reset", ais_chg, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule